// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesis Core

This block produces one unsigned 10-bit DAC code per clock. A 28-bit phase register advances by a frequency tuning word on every clock. Its upper ten bits either address a sine table that is built at elaboration, or form a sawtooth, a triangle or a square shape directly. The output frequency is `tune_word * f_clk / 2^28`. At a 12 MHz sample clock, a step of 23 in the tuning word moves the output by about 1 Hz.

The chosen shape is then reduced in amplitude by an integer divisor of 1, 2, 5 or 10. The reduction is taken about mid-scale (512), so every amplitude setting stays centred on the DAC midpoint. A valid strobe marks the cycles whose output code comes from real phase data after reset. Callers should keep at least five to six samples per period. With a 12 MHz clock this means tuning words up to about 44739243.

Top module: `dds_wave_core`

## Requirements
- R1: On every clock that is not in reset, the phase register adds `tune_word` modulo 2^28. A tuning word of 0 holds the phase and gives a constant (DC) output.
- R2: The sine shape reads a 1024-entry table at address phase[27:18]. Entry i equals round(511.5 + 511.5·sin(2π·i/1024)).
- R3: `wave_sel` 2'b00 selects the sine shape.
- R4: `wave_sel` 2'b01 selects sawtooth, whose sample is phase[27:18]. `wave_sel` 2'b10 selects triangle, whose sample is phase[26:17] while phase[27] is 0 and the bitwise inverse of phase[26:17] while phase[27] is 1.
- R5: `wave_sel` 2'b11 selects square. Its sample is 1023 while phase[27] is 0 and 0 while phase[27] is 1.
- R6: The output is 512 + (sample − 512)/d, using signed division that truncates toward zero. d is 1, 2, 5 or 10 for `amp_code` values 1, 2, 5 or 10. Every other `amp_code` value uses d = 1.
- R7: The output produced after clock edge n reflects the phase, `wave_sel` and `amp_code` that were present before edge n−2. After reset is released, `dac_valid` rises after the third clock edge and stays high until the next reset.
- R8: A synchronous active-high `rst` sets the phase to 0, `dac_data` to 512 and `dac_valid` to 0.
- R9: Changing `wave_sel` or `amp_code` never disturbs the phase sequence.
- R10: The output period is 2^28/`tune_word` clocks, to within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 28 | Phase increment per clock |
| wave_sel | input | 2 | Shape select: 00 sine, 01 sawtooth, 10 triangle, 11 square |
| amp_code | input | 4 | Amplitude divisor code (1, 2, 5, 10) |
| dac_data | output | 10 | Unsigned sample code |
| dac_valid | output | 1 | High when `dac_data` comes from real phase data |

## Verification
Each sample appears three clock edges after the stimulus that shaped it. The bench therefore keeps a three-deep history of expected codes and compares the output sampled after edge n with the entry queued before edge n−2. Inputs are driven on the falling edge, and the model samples them shortly afterwards. This matches what the first pipeline stage captures on the next rising edge.

The reset latency is checked by counting falling edges until `dac_valid` rises. The period check measures the spacing of square-wave rising transitions once the pipeline has filled.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int PHASE_W   = 28;
    localparam int ADDR_W    = 10;
    localparam int SAMP_W    = 10;
    localparam int AMP_W     = 4;
    localparam int TAB_DEPTH = 1 << ADDR_W;
    localparam int MID_CODE  = 1 << (SAMP_W - 1);

    typedef logic [SAMP_W-1:0] samp_t;

    typedef enum logic [1:0] {
        WAVE_SINE   = 2'b00,
        WAVE_SAW    = 2'b01,
        WAVE_TRI    = 2'b10,
        WAVE_SQUARE = 2'b11
    } wave_e;

    typedef enum logic [1:0] {
        DIV_ONE,
        DIV_TWO,
        DIV_FIVE,
        DIV_TEN
    } div_e;

    typedef struct packed {
        logic  vld;
        div_e  div;
        samp_t samp;
    } raw_stage_t;

    typedef struct packed {
        logic                     vld;
        logic signed [SAMP_W:0]   offs;
    } scaled_stage_t;

    function automatic div_e decode_amp(input logic [AMP_W-1:0] code);
        case (code)
            4'd2:    return DIV_TWO;
            4'd5:    return DIV_FIVE;
            4'd10:   return DIV_TEN;
            default: return DIV_ONE;
        endcase
    endfunction

    function automatic int sine_point(input int idx);
        real half;
        real v;
        half = real'((1 << SAMP_W) - 1) / 2.0;
        v = half + half * $sin(2.0 * 3.14159265358979323846 * real'(idx) / real'(TAB_DEPTH));
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
#(
    parameter int PW = PHASE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] tune_i,
    output logic [PW-1:0] phase_o
);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_q + tune_i;
    end

    assign phase_o = phase_q;

    // R1: modular accumulation step
    p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase_q == PW'($past(phase_q) + $past(tune_i)));

endmodule

// File: rtl/dds_shape_gen.sv
module dds_shape_gen
    import dds_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [1:0]         wave_i,
    input  logic [AMP_W-1:0]   amp_i,
    output raw_stage_t         raw_o
);

    localparam int TRI_HI = PHASE_W - 2;

    samp_t sine_rom [TAB_DEPTH];

    for (genvar i = 0; i < TAB_DEPTH; i++) begin : g_sine
        localparam samp_t ENTRY = samp_t'(sine_point(i));
        assign sine_rom[i] = ENTRY;
    end

    logic [ADDR_W-1:0] addr;
    logic              half_sel;
    logic [ADDR_W-1:0] tri_bits;
    samp_t             shape;
    raw_stage_t        raw_q;

    assign addr     = phase_i[PHASE_W-1 -: ADDR_W];
    assign half_sel = phase_i[PHASE_W-1];
    assign tri_bits = phase_i[TRI_HI -: ADDR_W];

    always_comb begin
        case (wave_e'(wave_i))
            WAVE_SINE:   shape = sine_rom[addr];
            WAVE_SAW:    shape = addr;
            WAVE_TRI:    shape = half_sel ? ~tri_bits : tri_bits;
            WAVE_SQUARE: shape = half_sel ? '0 : '1;
            default:     shape = samp_t'(MID_CODE);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q.vld  <= 1'b0;
            raw_q.div  <= DIV_ONE;
            raw_q.samp <= samp_t'(MID_CODE);
        end else begin
            raw_q.vld  <= 1'b1;
            raw_q.div  <= decode_amp(amp_i);
            raw_q.samp <= shape;
        end
    end

    assign raw_o = raw_q;

    // R5: square only ever reaches the two rails
    p_square_rails_r5: assert property (@(posedge clk) disable iff (rst)
        wave_i == WAVE_SQUARE |=> (raw_q.samp == '0 || raw_q.samp == '1));

endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale
    import dds_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  raw_stage_t raw_i,
    output samp_t      dac_o,
    output logic       vld_o
);

    localparam int SW1 = SAMP_W + 1;
    localparam logic signed [SAMP_W:0] MID_S = SW1'(MID_CODE);

    logic signed [SAMP_W:0] diff;
    logic signed [SAMP_W:0] quot;
    logic signed [SAMP_W:0] sum;
    scaled_stage_t          scl_q;
    samp_t                  dac_q;
    logic                   vld_q;

    assign diff = $signed({1'b0, raw_i.samp}) - MID_S;

    always_comb begin
        case (raw_i.div)
            DIV_TWO:  quot = SW1'(diff / 2);
            DIV_FIVE: quot = SW1'(diff / 5);
            DIV_TEN:  quot = SW1'(diff / 10);
            default:  quot = diff;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q.vld  <= 1'b0;
            scl_q.offs <= '0;
        end else begin
            scl_q.vld  <= raw_i.vld;
            scl_q.offs <= quot;
        end
    end

    assign sum = scl_q.offs + MID_S;

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_q <= samp_t'(MID_CODE);
            vld_q <= 1'b0;
        end else begin
            dac_q <= samp_t'(sum);
            vld_q <= scl_q.vld;
        end
    end

    assign dac_o = dac_q;
    assign vld_o = vld_q;

    // R6: tenth-scale offsets stay within 512/10 of mid-scale
    p_tenth_span_r6: assert property (@(posedge clk) disable iff (rst)
        raw_i.div == DIV_TEN |=> (scl_q.offs >= -51 && scl_q.offs <= 51));

endmodule

// File: rtl/dds_wave_core.sv
module dds_wave_core
    import dds_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic [1:0]         wave_sel,
    input  logic [AMP_W-1:0]   amp_code,
    output logic [SAMP_W-1:0]  dac_data,
    output logic               dac_valid
);

    logic [PHASE_W-1:0] phase;
    raw_stage_t         raw;

    dds_phase_acc #(.PW(PHASE_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .tune_i  (tune_word),
        .phase_o (phase)
    );

    dds_shape_gen u_shape (
        .clk     (clk),
        .rst     (rst),
        .phase_i (phase),
        .wave_i  (wave_sel),
        .amp_i   (amp_code),
        .raw_o   (raw)
    );

    dds_amp_scale u_scale (
        .clk   (clk),
        .rst   (rst),
        .raw_i (raw),
        .dac_o (dac_data),
        .vld_o (dac_valid)
    );

    // R8: the first cycle after reset shows the quiet state
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dac_valid && dac_data == SAMP_W'(MID_CODE)));

    // R7: once valid, the strobe holds until reset
    p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
        dac_valid |=> dac_valid);

endmodule

// File: tb/dds_wave_core_test.sv
module dds_wave_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] tune_word = '0;
    logic [1:0]  wave_sel = 2'b00;
    logic [3:0]  amp_code = 4'd1;
    logic [9:0]  dac_data;
    logic        dac_valid;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles   = 0;
    bit    chk_en   = 1'b0;
    string cur_req  = "R8";

    always #4 clk = ~clk;

    dds_wave_core uut (
        .clk       (clk),
        .rst       (rst),
        .tune_word (tune_word),
        .wave_sel  (wave_sel),
        .amp_code  (amp_code),
        .dac_data  (dac_data),
        .dac_valid (dac_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic int sine_ref(input int i);
        real v;
        v = 511.5 + 511.5 * $sin(2.0 * 3.14159265358979323846 * real'(i) / real'(1024));
        return $rtoi(v + 0.5);
    endfunction

    function automatic int model(input logic [27:0] ph, input logic [1:0] w, input logic [3:0] c);
        int a, s, d;
        a = int'(ph[27:18]);
        case (w)
            2'b00:   s = sine_ref(a);
            2'b01:   s = a;
            2'b10:   s = ph[27] ? 1023 - int'(ph[26:17]) : int'(ph[26:17]);
            default: s = ph[27] ? 0 : 1023;
        endcase
        d = (c == 4'd2) ? 2 : (c == 4'd5) ? 5 : (c == 4'd10) ? 10 : 1;
        return 512 + (s - 512) / d;
    endfunction

    // reference pipeline: entry queued before edge m is due after edge m+2
    logic [27:0] mphase = '0;
    bit hv [3];
    int hd [3];

    always @(negedge clk) begin
        #1;
        cycles++;
        if (chk_en) begin
            if (hv[2]) begin
                check(dac_valid == 1'b1, cur_req, int'(dac_valid), 1);
                check(int'(dac_data) == hd[2], cur_req, int'(dac_data), hd[2]);
            end else begin
                check(dac_valid == 1'b0 && dac_data == 10'd512, "R8", int'(dac_data), 512);
            end
        end
        hv[2] = hv[1]; hd[2] = hd[1];
        hv[1] = hv[0]; hd[1] = hd[0];
        if (rst) begin
            hv[0] = 0; hv[1] = 0; hv[2] = 0;
            hd[0] = 512;
            mphase = '0;
        end else begin
            hv[0] = 1;
            hd[0] = model(mphase, wave_sel, amp_code);
            mphase = mphase + tune_word;
        end
    end

    always @(posedge clk) begin
        if (cycles >= 150000) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        cur_req = "R8";
        @(negedge clk); rst = 1'b1; tune_word = 28'd5000000;
        run(3);
        check(dac_data == 10'd512, "R8 reset data", int'(dac_data), 512);
        check(dac_valid == 1'b0, "R8 reset valid", int'(dac_valid), 0);
        rst = 1'b0;
        run(2);
        check(dac_valid == 1'b0, "R8 valid low before pipeline fills", int'(dac_valid), 0);
    endtask

    task automatic t_latency;
        int n;
        cur_req = "R7";
        @(negedge clk); rst = 1'b1; wave_sel = 2'b01; amp_code = 4'd1; tune_word = 28'd3000000;
        run(2);
        rst = 1'b0;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            n++;
            if (dac_valid) break;
        end
        check(n == 3, "R7 valid latency", n, 3);
        check(dac_data == 10'd0, "R7 first sample from phase zero", int'(dac_data), 0);
        run(50);
    endtask

    task automatic t_shape(input logic [1:0] w, input string req, input logic [27:0] tw);
        cur_req = req;
        @(negedge clk); wave_sel = w; amp_code = 4'd1; tune_word = tw;
        run(1500);
    endtask

    task automatic t_amp;
        logic [3:0] codes [8] = '{4'd1, 4'd2, 4'd5, 4'd10, 4'd0, 4'd3, 4'd15, 4'd9};
        cur_req = "R6";
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 8; k++) begin
                @(negedge clk); wave_sel = 2'(w); amp_code = codes[k]; tune_word = 28'd1500000;
                run(200);
            end
        end
    endtask

    task automatic t_switch;
        cur_req = "R9";
        @(negedge clk); tune_word = 28'd2236962;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            wave_sel = 2'(k % 4);
            amp_code = (k % 3 == 0) ? 4'd5 : (k % 3 == 1) ? 4'd10 : 4'd2;
            run(37);
        end
    endtask

    task automatic t_wrap;
        int held;
        cur_req = "R1";
        @(negedge clk); wave_sel = 2'b01; amp_code = 4'd1; tune_word = 28'hFFFFFFF;
        run(300);
        tune_word = 28'd44739243;
        run(300);
        tune_word = 28'd0;
        run(5);
        held = int'(dac_data);
        run(20);
        check(int'(dac_data) == held, "R1 zero tuning word holds output", int'(dac_data), held);
    endtask

    task automatic t_period(input logic [27:0] tw);
        int  last, gap;
        bit  seen;
        real ideal;
        logic [9:0] prev;
        cur_req = "R10";
        @(negedge clk); wave_sel = 2'b11; amp_code = 4'd1; tune_word = tw;
        run(6);
        ideal = 268435456.0 / real'(tw);
        seen = 0; last = 0; prev = dac_data;
        for (int i = 0; i < 6 * $rtoi(ideal) + 20; i++) begin
            @(negedge clk); #2;
            if (prev == 10'd0 && dac_data == 10'd1023) begin
                if (seen) begin
                    gap = i - last;
                    check((real'(gap) - ideal) < 1.0 && (ideal - real'(gap)) < 1.0,
                          "R10 period", gap, $rtoi(ideal));
                end
                seen = 1; last = i;
            end
            prev = dac_data;
        end
    endtask

    initial begin
        hv[0] = 0; hv[1] = 0; hv[2] = 0;
        hd[0] = 512; hd[1] = 512; hd[2] = 512;
        run(3);
        chk_en = 1'b1;
        t_reset;
        t_latency;
        t_shape(2'b00, "R3 sine (R2 table)", 28'd262144);
        t_shape(2'b00, "R2 sine fine step", 28'd23456);
        t_shape(2'b01, "R4 sawtooth", 28'd700001);
        t_shape(2'b10, "R4 triangle", 28'd900007);
        t_shape(2'b11, "R5 square", 28'd1342177);
        t_amp;
        t_switch;
        t_wrap;
        t_period(28'd4194304);
        t_period(28'd1000000);
        t_period(28'd44739243);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule